// File: doc/BRIEF.md
# NMI Edge Detector With Polarity Blanking

This block watches one asynchronous non-maskable interrupt pin and decides whether a transition on it becomes a request to the processor. The pin is brought into the clock domain through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. A software-controlled polarity bit selects whether rising or falling transitions count.

Changing the polarity bit can make the comparison see a phantom transition. For this reason, edge evaluation is suppressed for a fixed window after the bit takes a new value. A further change during that window restarts it.

An accepted edge sets a sticky pending flag, which the processor clears with an acknowledge pulse. While the flag is set, the block presents a request level above every maskable source. Acceptance depends on a mask-all bit, a block-mask enable, the processor's exception-block bit and the current power state. In standby, an edge that is not masked off also produces a one-cycle wake pulse.

Top module: `nmi_edge_gate`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `nmi_pend_o` and `wake_o` are 0 and `nmi_level_o` is 0.
- R2: With `edge_rise_sel_i`=1 (rising selected), a 0-to-1 pin change sampled at clock edge k sets `nmi_pend_o` at clock edge k+2, when accepted. A 1-to-0 change does nothing.
- R3: With `edge_rise_sel_i`=0 (falling selected), a 1-to-0 pin change sets `nmi_pend_o` with the same two-clock latency. A 0-to-1 change does nothing.
- R4: A clock edge at which `edge_rise_sel_i` differs from its value at the previous edge starts a blanking window. No pin edge is detected at that clock edge or at the next `BLANK_CYCLES` (default 20) clock edges.
- R5: A further change of `edge_rise_sel_i` inside the blanking window restarts the full window from the new change.
- R6: `pwr_state_i` encodes 2'b00 run, 2'b01 sleep, 2'b10 standby and 2'b11 (treated as run). In run, a detected edge is accepted only if `mask_all_i`=0 and either `blk_mask_en_i`=1 or `cpu_block_i`=0. A rejected edge is discarded and is not remembered.
- R7: In sleep or standby, `cpu_block_i` has no effect on acceptance, and `mask_all_i`=1 still rejects the edge.
- R8: `nmi_pend_o` stays set until a clock edge with `nmi_ack_i`=1 clears it. If an edge is accepted at the same clock edge as the acknowledge, the flag stays set.
- R9: `wake_o` is a one-cycle pulse, asserted at the same clock edge as the pending update, for a detected edge while `pwr_state_i` is standby and `mask_all_i`=0.
- R10: `nmi_level_o` reads 16 while `nmi_pend_o` is set and 0 otherwise. Maskable sources cannot exceed 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_pin_i | input | 1 | Asynchronous interrupt pin |
| edge_rise_sel_i | input | 1 | 1 = rising edge, 0 = falling edge |
| pwr_state_i | input | 2 | Power state: 00 run, 01 sleep, 10 standby, 11 run |
| blk_mask_en_i | input | 1 | Accept despite the processor block bit |
| cpu_block_i | input | 1 | Processor exception-block bit |
| mask_all_i | input | 1 | Rejects every edge when 1 |
| nmi_ack_i | input | 1 | Clears the pending flag |
| nmi_pend_o | output | 1 | Sticky pending request |
| wake_o | output | 1 | One-cycle standby wake pulse |
| nmi_level_o | output | 5 | Request priority level (16 or 0) |

## Verification
Two events can land on the same clock edge: the processor's acknowledge, and the acceptance of a fresh edge. When they coincide, the set must win. The bench provokes this by first leaving a request pending. It then moves the pin so that the synchronized edge is evaluated at exactly the edge where the acknowledge is driven, two clocks after the pin changes. A behavioural reference model decides the flag after every clock, and the design's flag must match it. A second overlap, a polarity change on the same edge as a pin transition, is driven in the same way and judged by the model.

// File: rtl/nmi_edge_pkg.sv
package nmi_edge_pkg;

  localparam int unsigned NMI_LEVEL   = 16;
  localparam int unsigned LEVEL_W     = $clog2(NMI_LEVEL + 1);

  typedef enum logic [1:0] {
    PWR_RUN     = 2'b00,
    PWR_SLEEP   = 2'b01,
    PWR_STANDBY = 2'b10,
    PWR_RSVD    = 2'b11
  } pwr_state_e;

  function automatic logic is_low_power(input pwr_state_e st);
    return (st == PWR_SLEEP) || (st == PWR_STANDBY);
  endfunction

endpackage

// File: rtl/nmi_pin_sync.sv
// Synchronizer chain plus one history flop; flags single-cycle edges.
module nmi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              hist_q, hist_d;

  always_comb begin
    sync_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    hist_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~hist_q;
  assign fall_o = ~sync_q[STAGES-1] &  hist_q;

endmodule

// File: rtl/nmi_blank_timer.sv
// Holds the applied polarity and suppresses detection after it changes.
module nmi_blank_timer #(
  parameter int unsigned BLANK_CYCLES = 20,
  parameter logic        SEL_RST      = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic sel_o,
  output logic blank_o
);

  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES);

  logic             sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_change;
  logic             cnt_busy;
  logic             cnt_en;

  assign sel_change = sel_i ^ sel_q;
  assign cnt_busy   = (cnt_q != '0);
  assign cnt_en     = sel_change | cnt_busy;

  always_comb begin
    if (sel_change) begin
      cnt_d = CNT_LOAD;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_RST;
    end else begin
      sel_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign sel_o   = sel_q;
  assign blank_o = sel_change | cnt_busy;

endmodule

// File: rtl/nmi_accept_gate.sv
// Acceptance gating, sticky pending flag and standby wake pulse.
module nmi_accept_gate
  import nmi_edge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_hit_i,
  input  logic [1:0] pwr_state_i,
  input  logic       blk_mask_en_i,
  input  logic       cpu_block_i,
  input  logic       mask_all_i,
  input  logic       ack_i,
  output logic       pend_o,
  output logic       wake_o
);

  pwr_state_e pwr;
  logic       low_pwr;
  logic       accept;
  logic       take;
  logic       pend_q, pend_d;
  logic       wake_q, wake_d;

  assign pwr     = pwr_state_e'(pwr_state_i);
  assign low_pwr = is_low_power(pwr);
  assign accept  = ~mask_all_i & (low_pwr | blk_mask_en_i | ~cpu_block_i);
  assign take    = edge_hit_i & accept;

  always_comb begin
    pend_d = pend_q;
    if (take) begin
      pend_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end
    wake_d = edge_hit_i & (pwr == PWR_STANDBY) & ~mask_all_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wake_q <= wake_d;
    end
  end

  assign pend_o = pend_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/nmi_edge_gate.sv
module nmi_edge_gate
  import nmi_edge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BLANK_CYCLES = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nmi_pin_i,
  input  logic               edge_rise_sel_i,
  input  logic [1:0]         pwr_state_i,
  input  logic               blk_mask_en_i,
  input  logic               cpu_block_i,
  input  logic               mask_all_i,
  input  logic               nmi_ack_i,
  output logic               nmi_pend_o,
  output logic               wake_o,
  output logic [LEVEL_W-1:0] nmi_level_o
);

  logic rise, fall;
  logic sel_applied, blank;
  logic edge_hit;

  nmi_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (nmi_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  nmi_blank_timer #(
    .BLANK_CYCLES (BLANK_CYCLES),
    .SEL_RST      (1'b0)
  ) u_blank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (edge_rise_sel_i),
    .sel_o   (sel_applied),
    .blank_o (blank)
  );

  assign edge_hit = ~blank & (sel_applied ? rise : fall);

  nmi_accept_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .edge_hit_i    (edge_hit),
    .pwr_state_i   (pwr_state_i),
    .blk_mask_en_i (blk_mask_en_i),
    .cpu_block_i   (cpu_block_i),
    .mask_all_i    (mask_all_i),
    .ack_i         (nmi_ack_i),
    .pend_o        (nmi_pend_o),
    .wake_o        (wake_o)
  );

  assign nmi_level_o = nmi_pend_o ? LEVEL_W'(NMI_LEVEL) : '0;

endmodule

// File: rtl/nmi_edge_gate_chk.sv
module nmi_edge_gate_chk
  import nmi_edge_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               nmi_pin_i,
  input logic               edge_rise_sel_i,
  input logic [1:0]         pwr_state_i,
  input logic               blk_mask_en_i,
  input logic               cpu_block_i,
  input logic               mask_all_i,
  input logic               nmi_ack_i,
  input logic               nmi_pend_o,
  input logic               wake_o,
  input logic [LEVEL_W-1:0] nmi_level_o
);

  localparam int unsigned SW = $clog2(BLANK_CYCLES + 2);
  localparam logic [SW-1:0] S_MAX = SW'(BLANK_CYCLES + 1);

  logic          sel_seen;
  logic [SW-1:0] since;
  logic          sel_moved;
  logic          in_window;

  assign sel_moved = edge_rise_sel_i != sel_seen;
  assign in_window = sel_moved | (since < SW'(BLANK_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_seen <= 1'b0;
      since    <= S_MAX;
    end else begin
      sel_seen <= edge_rise_sel_i;
      if (sel_moved) begin
        since <= '0;
      end else if (since != S_MAX) begin
        since <= since + SW'(1);
      end
    end
  end

  // R4 / R5: nothing becomes pending inside the blanking window
  p_blank_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_window && !nmi_pend_o |=> !nmi_pend_o);

  // R6 / R7: mask-all keeps the flag from rising
  p_mask_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_all_i && !nmi_pend_o |=> !nmi_pend_o);

  // R6: run state with block bit set and no block-mask rejects
  p_run_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_low_power(pwr_state_e'(pwr_state_i)) && cpu_block_i && !blk_mask_en_i
      && !nmi_pend_o |=> !nmi_pend_o);

  // R8: sticky until acknowledged
  p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend_o && !nmi_ack_i |=> nmi_pend_o);

  // R9: wake only from unmasked standby, and only one cycle wide
  p_wake_standby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(pwr_state_i) == PWR_STANDBY && !$past(mask_all_i));

  p_wake_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R10: level is either zero or a single weight
  p_level_shape_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nmi_level_o));

endmodule

bind nmi_edge_gate nmi_edge_gate_chk #(.BLANK_CYCLES(BLANK_CYCLES)) u_chk (.*);

// File: tb/nmi_edge_gate_bench.sv
`timescale 1ns/1ps
module nmi_edge_gate_bench;
  import nmi_edge_pkg::*;

  localparam int BLANK = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, sel, blk_en, cpu_blk, mask_all, ack;
  logic [1:0] pwr;
  logic       pend, wake;
  logic [4:0] level;

  always #2 clk = ~clk;

  nmi_edge_gate #(.SYNC_STAGES(2), .BLANK_CYCLES(BLANK)) u_nmi_edge_gate (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .nmi_pin_i       (pin),
    .edge_rise_sel_i (sel),
    .pwr_state_i     (pwr),
    .blk_mask_en_i   (blk_en),
    .cpu_block_i     (cpu_blk),
    .mask_all_i      (mask_all),
    .nmi_ack_i       (ack),
    .nmi_pend_o      (pend),
    .wake_o          (wake),
    .nmi_level_o     (level)
  );

  int    tests = 0;
  int    fails = 0;
  string tag   = "R1";
  bit    done  = 0;

  // Behavioural reference model
  int   n_edge, last_chg;
  logic p1, p2, p3, sel_prev;
  logic m_pend, m_wake;

  always @(posedge clk) begin
    if (!rst_n) begin
      n_edge = 0; last_chg = -1000;
      p1 = 0; p2 = 0; p3 = 0; sel_prev = 0;
      m_pend = 0; m_wake = 0;
    end else begin
      logic blanked, hit, acc, lowp;
      n_edge++;
      if (sel != sel_prev) last_chg = n_edge;
      sel_prev = sel;
      blanked = (n_edge - last_chg) <= BLANK;
      hit = !blanked && (sel ? (p2 && !p3) : (!p2 && p3));
      lowp = (pwr == 2'b01) || (pwr == 2'b10);
      acc = !mask_all && (lowp || blk_en || !cpu_blk);
      m_wake = hit && (pwr == 2'b10) && !mask_all;
      if (hit && acc) m_pend = 1;
      else if (ack)   m_pend = 0;
      p3 = p2; p2 = p1; p1 = pin;
    end
  end

  task automatic check1(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check1(tag, "pend", pend, m_pend);
      check1(tag, "wake", wake, m_wake);
      check1("R10", "level", level, m_pend ? 16 : 0);
    end
  end

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic toggle_pin();
    pin = 1'b1; tick(4);
    pin = 1'b0; tick(4);
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1);
    ack = 1'b0; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; pin = 0; sel = 0; blk_en = 0; cpu_blk = 0;
    mask_all = 0; ack = 0; pwr = 2'b00;
    tick(3);
    check1("R1", "reset pend", pend, 0);
    check1("R1", "reset wake", wake, 0);
    check1("R1", "reset level", level, 0);
    rst_n = 1;
    tick(1);
    check1("R1", "post-reset pend", pend, 0);

    // R4: polarity change together with a pin edge
    tag = "R4";
    sel = 1; pin = 1; tick(4); pin = 0; tick(BLANK + 6);
    check1("R4", "blanked edge", pend, 0);

    // R2: rising detected, falling ignored
    tag = "R2";
    pin = 1; tick(3);
    check1("R2", "rise latency", pend, 1);
    tick(2); do_ack();
    pin = 0; tick(5);
    check1("R2", "fall ignored", pend, 0);

    // R3: falling selected
    tag = "R3";
    sel = 0; tick(BLANK + 4);
    pin = 1; tick(5);
    check1("R3", "rise ignored", pend, 0);
    pin = 0; tick(3);
    check1("R3", "fall latency", pend, 1);
    do_ack();

    // R5: window restarts on a second change
    tag = "R5";
    sel = 1; tick(15); sel = 0; tick(10);
    pin = 1; tick(4); pin = 0; tick(4);
    check1("R5", "restarted window", pend, 0);
    tick(BLANK + 4);

    // R6: run-state gating
    tag = "R6";
    cpu_blk = 1; blk_en = 0; toggle_pin();
    check1("R6", "blocked", pend, 0);
    pwr = 2'b11; toggle_pin();
    check1("R6", "reserved as run", pend, 0);
    pwr = 2'b00; blk_en = 1; toggle_pin();
    check1("R6", "block mask", pend, 1);
    do_ack();
    mask_all = 1; toggle_pin();
    check1("R6", "mask all", pend, 0);
    mask_all = 0; blk_en = 0; cpu_blk = 0; toggle_pin();
    check1("R6", "unblocked", pend, 1);
    do_ack();

    // R7: low power ignores the block bit
    tag = "R7";
    cpu_blk = 1; pwr = 2'b01; toggle_pin();
    check1("R7", "sleep accept", pend, 1);
    do_ack();
    mask_all = 1; toggle_pin();
    check1("R7", "sleep mask all", pend, 0);

    // R9: standby wake
    tag = "R9";
    pwr = 2'b10; mask_all = 0;
    pin = 1; tick(4); pin = 0; tick(3);
    check1("R9", "wake pulse", wake, 1);
    tick(1);
    check1("R9", "wake one cycle", wake, 0);
    do_ack();
    mask_all = 1; toggle_pin();
    check1("R9", "masked no wake", pend, 0);
    mask_all = 0; cpu_blk = 0; pwr = 2'b00;

    // R8: accepted edge and acknowledge on the same clock edge
    tag = "R8";
    toggle_pin();
    check1("R8", "pending set", pend, 1);
    pin = 1; tick(4);
    pin = 0; tick(2);
    ack = 1; tick(1); ack = 0;
    check1("R8", "set beats ack", pend, 1);
    tick(2); do_ack();
    check1("R8", "ack clears", pend, 0);

    // Mixed random traffic, judged by the model each clock
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) pin = ~pin;
      if ($urandom_range(0, 60) == 0) sel = ~sel;
      if ($urandom_range(0, 20) == 0) pwr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) mask_all = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) cpu_blk = ~cpu_blk;
      if ($urandom_range(0, 15) == 0) blk_en = ~blk_en;
      ack = ($urandom_range(0, 7) == 0);
      tick(1);
    end
    ack = 0; tick(2);
    finish_run();
  end

endmodule